// File: doc/BRIEF.md
# Handshaked Sequential Bubble Sorter

This block sorts a set of signed two's-complement operands into ascending order. It raises an input-request strobe when idle. A producer then presents all operands at once on a parallel bus and raises input-ok. The block latches the set and sorts it in place with one adjacent compare-and-swap per clock. A full walk over the set is a pass. The sort stops after a pass that made no swap, or after the last possible pass.

When the sort is finished, the block raises an output-ready strobe and holds the sorted set steady on its outputs. The consumer answers with output-ok, and the block then goes back to requesting input. Reset is synchronous and active high. The operand width and the operand count are parameters, 8 and 8 by default.

Top module: `bubble_sorter`

## Requirements
- R1: While reset is high and in the first cycle after it, in_req is 1 and out_rdy is 0.
- R2: Operands are captured on a clock edge where in_ok and in_req are both 1. From the next cycle, in_req stays 0 until the result has been acknowledged.
- R3: When out_rdy is 1, out_vals is in ascending signed order. Element 0 (bits W-1:0) holds the smallest value. The values are W-bit two's complement, for example -128 to 127 at W=8.
- R4: The outputs are a permutation of the captured operands, with duplicates preserved. Element i of in_vals sits at bits i*W+W-1 down to i*W.
- R5: While out_rdy is 1 and out_ok is 0, out_rdy stays 1 and out_vals does not change.
- R6: An edge that sees out_ok while out_rdy is 1 clears out_rdy and sets in_req on the next cycle.
- R7: in_ok and in_vals are ignored while in_req is 0. Holding in_ok high with new data during a sort does not change the result.
- R8: An input set that is already ascending, including an all-equal set, raises out_rdy exactly N-1 clock edges after the capture edge. This is the early stop after one pass with no swap.
- R9: A strictly descending input set raises out_rdy exactly (N-1)*(N-1) edges after capture. This is the longest case.
- R10: out_ok asserted while out_rdy is 0 has no effect: in_req stays 1 and out_rdy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_ok | input | 1 | Producer marks in_vals valid |
| out_ok | input | 1 | Consumer acknowledges the result |
| in_vals | input | N*W | N packed signed operands |
| in_req | output | 1 | Sorter ready for a new set |
| out_rdy | output | 1 | Sorted result present and held |
| out_vals | output | N*W | N packed sorted values, ascending |

## Verification
The bench builds the block with the defaults of eight 8-bit operands. At that size the numeric extremes -128 and 127 can be driven directly, and a reversed set needs the full 49-cycle worst case. That case is measured exactly, next to the 7-cycle early stop for ascending and all-equal sets. At eight elements, duplicates and mixed signs can also appear together in one set, so the signed comparison and duplicate handling are tested in the same pass.

// File: rtl/bubble_sorter.sv
module bubble_sorter #(
  parameter int W = 8,
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_ok,
  input  logic             out_ok,
  input  logic [N-1:0][W-1:0] in_vals,
  output logic             in_req,
  output logic             out_rdy,
  output logic [N-1:0][W-1:0] out_vals
);
  localparam int IW = (N > 2) ? $clog2(N) : 1;

  typedef enum logic [1:0] {S_REQ, S_SORT, S_DONE} state_t;

  state_t               st;
  logic signed [W-1:0]  r [N];
  logic [IW-1:0]        idx, pass;
  logic                 swp;
  logic signed [W-1:0]  cur, nxt;
  logic                 do_swap, last_step;

  assign cur       = r[idx];
  assign nxt       = r[idx + IW'(1)];
  assign do_swap   = cur > nxt;
  assign last_step = (idx == IW'(N-2));
  assign in_req    = (st == S_REQ);
  assign out_rdy   = (st == S_DONE);

  for (genvar g = 0; g < N; g++) begin : g_out
    assign out_vals[g] = r[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_REQ;
      idx  <= '0;
      pass <= '0;
      swp  <= 1'b0;
      for (int i = 0; i < N; i++) r[i] <= '0;
    end else begin
      case (st)
        S_REQ: if (in_ok) begin
          for (int i = 0; i < N; i++) r[i] <= in_vals[i];
          idx  <= '0;
          pass <= '0;
          swp  <= 1'b0;
          st   <= S_SORT;
        end
        S_SORT: begin
          if (do_swap) begin
            r[idx]          <= nxt;
            r[idx + IW'(1)] <= cur;
          end
          if (last_step) begin
            idx <= '0;
            swp <= 1'b0;
            if (!(swp || do_swap) || pass == IW'(N-2)) st <= S_DONE;
            else pass <= pass + IW'(1);
          end else begin
            idx <= idx + IW'(1);
            swp <= swp | do_swap;
          end
        end
        S_DONE: if (out_ok) st <= S_REQ;
        default: st <= S_REQ;
      endcase
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> in_req && !out_rdy);
  a_r2_req_drops: assert property (@(posedge clk) disable iff (rst)
    in_req && in_ok |=> !in_req);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    out_rdy && !out_ok |=> out_rdy && $stable(out_vals));
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    out_rdy && out_ok |=> in_req && !out_rdy);
  a_r10_ack_ignored: assert property (@(posedge clk) disable iff (rst)
    in_req && !in_ok |=> in_req);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(in_req && out_rdy));

  always_ff @(posedge clk) begin
    if (!rst && out_rdy) begin
      for (int i = 0; i < N-1; i++) begin
        a_r3_ordered: assert ($signed(out_vals[i]) <= $signed(out_vals[i+1]));
      end
    end
  end
endmodule

// File: tb/sim_bubble_sorter.sv
module sim_bubble_sorter;
  localparam int W = 8;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, in_ok, out_ok;
  logic [N-1:0][W-1:0] in_vals;
  logic in_req, out_rdy;
  logic [N-1:0][W-1:0] out_vals;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bubble_sorter #(.W(W), .N(N)) u0 (
    .clk(clk), .rst(rst), .in_ok(in_ok), .out_ok(out_ok),
    .in_vals(in_vals), .in_req(in_req), .out_rdy(out_rdy), .out_vals(out_vals)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sort(input logic signed [W-1:0] v [N], input int exp_lat,
                          input bit hold_inok, input string tag);
    logic signed [W-1:0] e [N];
    logic signed [W-1:0] t;
    int cnt;
    logic [N-1:0][W-1:0] snap;
    for (int i = 0; i < N; i++) e[i] = v[i];
    for (int i = 1; i < N; i++) begin
      t = e[i];
      for (int j = i; j > 0; j--) begin
        if (e[j-1] > t) begin e[j] = e[j-1]; e[j-1] = t; end
      end
    end
    cnt = 0;
    while (!in_req && cnt < 300) begin @(negedge clk); cnt++; end
    check({tag, " R2 in_req before capture"}, in_req, 1);
    for (int i = 0; i < N; i++) in_vals[i] = v[i];
    in_ok = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (hold_inok) for (int i = 0; i < N; i++) in_vals[i] = W'(8'h55 + i);
    else in_ok = 1'b0;
    check({tag, " R2 in_req low after capture"}, in_req, 0);
    cnt = 1;
    while (!out_rdy && cnt < 300) begin
      if (in_req) check({tag, " R2 in_req during sort"}, in_req, 0);
      @(negedge clk);
      cnt++;
    end
    cnt--;
    check({tag, " out_rdy reached"}, out_rdy, 1);
    if (exp_lat >= 0) check({tag, " R8/R9 latency"}, cnt, exp_lat);
    for (int i = 0; i < N; i++)
      check({tag, " R3/R4 out value"}, $signed(out_vals[i]), e[i]);
    snap = out_vals;
    repeat (4) @(negedge clk);
    check({tag, " R5 out_rdy held"}, out_rdy, 1);
    check({tag, " R5 outputs stable"}, (out_vals == snap), 1);
    if (hold_inok) check({tag, " R7 in_ok ignored while busy"}, in_req, 0);
    out_ok = 1'b1;
    in_ok  = 1'b0;
    @(negedge clk);
    out_ok = 1'b0;
    check({tag, " R6 out_rdy cleared"}, out_rdy, 0);
    check({tag, " R6 in_req back"}, in_req, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_ok = 1'b0; out_ok = 1'b0; in_vals = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 in_req in reset", in_req, 1);
    check("R1 out_rdy in reset", out_rdy, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_req after reset", in_req, 1);
    check("R1 out_rdy after reset", out_rdy, 0);
  endtask

  task automatic t_ack_idle();
    out_ok = 1'b1;
    repeat (3) @(negedge clk);
    out_ok = 1'b0;
    check("R10 in_req kept", in_req, 1);
    check("R10 out_rdy kept low", out_rdy, 0);
  endtask

  initial begin
    logic signed [W-1:0] v [N];
    t_reset();
    t_ack_idle();
    v = '{-76, 1, 12, 85, 15, 103, -2, 3};
    run_sort(v, -1, 1'b0, "mixed");
    v = '{-128, -5, 0, 1, 2, 40, 90, 127};
    run_sort(v, N-1, 1'b0, "ascending");
    v = '{5, 5, 5, 5, 5, 5, 5, 5};
    run_sort(v, N-1, 1'b0, "equal");
    v = '{127, 100, 50, 0, -1, -50, -100, -128};
    run_sort(v, (N-1)*(N-1), 1'b0, "reversed");
    v = '{3, -128, 127, 3, -1, 127, -128, 0};
    run_sort(v, -1, 1'b1, "dups_hold");
    t_ack_idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule